// File: doc/BRIEF.md
# DMA Request Sense and Acknowledge Handshake

This block sits between one external DMA request pin and the sequencer of a single DMA channel. The raw request pin is first resynchronised into the block clock. It is then judged in one of two ways. In level mode a request exists for as long as the pin sits at its active level. In edge mode a single transition in the active direction is remembered until the sequencer takes it. A sense bit chooses low/falling or high/rising as the active form.

The sequencer sees requests on a valid/ready pair. `req_valid` never depends on `req_ready`, and a request counts as accepted on any cycle where both are high. In edge mode a pending request stays valid until it is accepted, so the sequencer can apply back-pressure for as long as it needs without losing a request. In level mode `req_valid` simply tracks the synchronised pin, so holding `req_ready` low only postpones service.

Each accepted request drives the acknowledge pin, whose active polarity is programmable. In cycle-steal mode the pin is active for one cycle per acceptance. In burst mode it stays active until the sequencer signals the end of the transfer. Level sensing combined with burst is an illegal pairing. It raises a configuration-error flag and blocks all acceptance. A hard reset or the standby input clears all four control bits. Module standby parks the block but leaves the control bits intact.

Top module: `dma_req_ack`

## Requirements
- R1: After reset, and after any cycle with `standby` high, all control bits are 0. The block therefore uses level mode with low sense, cycle-steal transfers and an active-low acknowledge: `ack_pin` idles at 1, `cfg_err` is 0, and a low pin produces `req_valid` two cycles later.
- R2: With ack-high 0 the acknowledge pin is active at 0 and idles at 1. With ack-high 1 it is active at 1 and idles at 0.
- R3: In level mode (edge-mode bit 0), `req_valid` goes to 1 on the second rising clock edge after the pin reaches its active level. It goes back to 0 on the second edge after the pin leaves that level.
- R4: In edge mode (edge-mode bit 1), an active transition on the pin raises `req_valid` on the third rising edge after the change. It then holds `req_valid` while `req_ready` is 0 and drops it on the edge that accepts it.
- R5: With sense-high 0 the active level is low and the active edge is falling. With sense-high 1 they are high and rising. The inactive level and the opposite edge never create a request.
- R6: In cycle-steal mode (burst bit 0), each acceptance makes the acknowledge active during exactly the one cycle after the accepting edge.
- R7: In burst mode (burst bit 1), the acknowledge is active from the cycle after acceptance. It stays active until the edge that samples `xfer_done` high and is inactive in the cycle after that.
- R8: `cfg_err` is 1 exactly when the edge-mode bit is 0 and the burst bit is 1. While it is 1, `req_valid` stays 0 and the acknowledge stays inactive whatever the pin does.
- R9: While `mod_stby` is 1, the acknowledge is forced inactive, `req_valid` is 0, and pin edges are not remembered. The stored control bits keep their values across module standby.
- R10: A configuration write discards any remembered edge and ends any active acknowledge at the writing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| standby | input | 1 | Standby; clears control bits and state |
| mod_stby | input | 1 | Module standby; parks the block, keeps control bits |
| cfg_we | input | 1 | Write strobe for the four control bits |
| cfg_ack_high | input | 1 | Acknowledge active level (1 = high) |
| cfg_edge_mode | input | 1 | Request detection (0 = level, 1 = edge) |
| cfg_sense_high | input | 1 | Request sense (0 = low/falling, 1 = high/rising) |
| cfg_burst_mode | input | 1 | Bus mode (0 = cycle-steal, 1 = burst) |
| req_pin | input | 1 | Raw asynchronous DMA request pin |
| req_valid | output | 1 | Request pending towards the sequencer |
| req_ready | input | 1 | Sequencer accepts the pending request |
| xfer_done | input | 1 | One-cycle end-of-transfer pulse (burst) |
| ack_pin | output | 1 | DMA acknowledge pin, polarity per control bit |
| cfg_err | output | 1 | Level detection combined with burst selected |

## Verification
The bench sweeps all sixteen control combinations. For each one it measures the exact edge at which `req_valid` appears. A design with a missing or extra synchroniser stage would shift that edge by one cycle, and a design that confused level and edge sensing would either drop the request under back-pressure or keep it after the pin returned. The bench holds acceptance off for several cycles and reverses the pin in the meantime. This catches an edge detector that forgets a request or fires on the wrong direction. In each mode it counts how many cycles the acknowledge stays active, which exposes a cycle-steal pulse that lingers and a burst that ends before `xfer_done`. Module standby is entered with a burst in progress, and the bench then checks the idle acknowledge level and whether edge mode survives. A design that reset its bits there would come back with the wrong idle acknowledge level and in level mode.

// File: rtl/dra_pkg.sv
package dra_pkg;
  typedef struct packed {
    logic ack_high;
    logic edge_mode;
    logic sense_high;
    logic burst_mode;
  } dra_cfg_t;

  localparam int unsigned DRA_SYNC_STAGES = 2;
endpackage

// File: rtl/dra_cfg_regs.sv
module dra_cfg_regs
  import dra_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     standby,
  input  logic     we,
  input  dra_cfg_t d,
  output dra_cfg_t q
);
  // Hard reset and standby both clear; module standby is deliberately absent.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (standby) q <= '0;
    else if (we)      q <= d;
  end
endmodule

// File: rtl/dra_sync.sv
module dra_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[LAST];
endmodule

// File: rtl/dra_detect.sv
module dra_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic edge_mode,
  input  logic sense_high,
  input  logic samp,
  input  logic accept,
  output logic pending
);
  logic prev;
  logic edge_pend;
  logic lvl_hit;
  logic edge_hit;

  // Previous synchronised sample; reset to the idle level of the default sense.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= samp;
  end

  assign lvl_hit  = (samp == sense_high);
  assign edge_hit = sense_high ? (samp & ~prev) : (~samp & prev);

  // A fresh edge wins over a same-cycle acceptance so it is not lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    edge_pend <= 1'b0;
    else if (flush || !edge_mode)  edge_pend <= 1'b0;
    else if (edge_hit)             edge_pend <= 1'b1;
    else if (accept)               edge_pend <= 1'b0;
  end

  assign pending = edge_mode ? edge_pend : lvl_hit;
endmodule

// File: rtl/dra_ack.sv
module dra_ack (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic park,
  input  logic burst_mode,
  input  logic ack_high,
  input  logic accept,
  input  logic xfer_done,
  output logic ack_pin
);
  logic active;
  logic on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          active <= 1'b0;
    else if (flush)      active <= 1'b0;
    else if (burst_mode) begin
      if (accept)         active <= 1'b1;
      else if (xfer_done) active <= 1'b0;
    end else              active <= accept;
  end

  assign on      = active & ~park;
  assign ack_pin = ack_high ? on : ~on;
endmodule

// File: rtl/dma_req_ack.sv
module dma_req_ack
  import dra_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DRA_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic standby,
  input  logic mod_stby,
  input  logic cfg_we,
  input  logic cfg_ack_high,
  input  logic cfg_edge_mode,
  input  logic cfg_sense_high,
  input  logic cfg_burst_mode,
  input  logic req_pin,
  output logic req_valid,
  input  logic req_ready,
  input  logic xfer_done,
  output logic ack_pin,
  output logic cfg_err
);
  dra_cfg_t cfg_d;
  dra_cfg_t cfg_q;
  logic     samp;
  logic     pend;
  logic     blocked;
  logic     flush;
  logic     accept;

  assign cfg_d = '{ack_high:   cfg_ack_high,
                   edge_mode:  cfg_edge_mode,
                   sense_high: cfg_sense_high,
                   burst_mode: cfg_burst_mode};

  dra_cfg_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .standby (standby),
    .we      (cfg_we),
    .d       (cfg_d),
    .q       (cfg_q)
  );

  dra_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (req_pin),
    .q     (samp)
  );

  assign cfg_err   = ~cfg_q.edge_mode & cfg_q.burst_mode;
  assign blocked   = standby | mod_stby | cfg_err;
  assign flush     = blocked | cfg_we;
  assign req_valid = pend & ~blocked;
  assign accept    = req_valid & req_ready;

  dra_detect u_det (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .edge_mode  (cfg_q.edge_mode),
    .sense_high (cfg_q.sense_high),
    .samp       (samp),
    .accept     (accept),
    .pending    (pend)
  );

  dra_ack u_ack (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .park       (mod_stby),
    .burst_mode (cfg_q.burst_mode),
    .ack_high   (cfg_q.ack_high),
    .accept     (accept),
    .xfer_done  (xfer_done),
    .ack_pin    (ack_pin)
  );
endmodule

// File: rtl/dra_chk.sv
module dra_chk
  import dra_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     standby,
  input logic     mod_stby,
  input logic     cfg_we,
  input logic     req_valid,
  input logic     req_ready,
  input logic     xfer_done,
  input logic     ack_pin,
  input logic     cfg_err,
  input logic     acc,
  input dra_cfg_t cfg
);
  // R8
  err_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!req_valid && ack_pin != cfg.ack_high));

  // R1
  stby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (ack_pin && !cfg_err));

  // R9
  mstby_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mod_stby |-> (ack_pin == !cfg.ack_high && !req_valid));

  // R6
  cs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !cfg.burst_mode && !cfg_we && !standby) |=> (mod_stby || ack_pin == cfg.ack_high));

  // R6
  cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !cfg.burst_mode && !cfg_we && !standby) |=> (ack_pin != cfg.ack_high));

  // R7
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.burst_mode && ack_pin == cfg.ack_high && !xfer_done && !cfg_we && !standby && !mod_stby)
      |=> (mod_stby || ack_pin == cfg.ack_high));

  // R7
  burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.burst_mode && xfer_done && !acc && !cfg_we && !standby) |=> (ack_pin != cfg.ack_high));

  // R4
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && cfg.edge_mode && !cfg_we && !standby)
      |=> (req_valid || mod_stby || standby));
endmodule

bind dma_req_ack dra_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .standby   (standby),
  .mod_stby  (mod_stby),
  .cfg_we    (cfg_we),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .xfer_done (xfer_done),
  .ack_pin   (ack_pin),
  .cfg_err   (cfg_err),
  .acc       (accept),
  .cfg       (cfg_q)
);

// File: tb/dma_req_ack_tb.sv
module dma_req_ack_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 50000;

  logic clk = 1'b0;
  logic rst_n, standby, mod_stby, cfg_we;
  logic cfg_ack_high, cfg_edge_mode, cfg_sense_high, cfg_burst_mode;
  logic req_pin, req_ready, xfer_done;
  logic req_valid, ack_pin, cfg_err;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_req_ack u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .standby        (standby),
    .mod_stby       (mod_stby),
    .cfg_we         (cfg_we),
    .cfg_ack_high   (cfg_ack_high),
    .cfg_edge_mode  (cfg_edge_mode),
    .cfg_sense_high (cfg_sense_high),
    .cfg_burst_mode (cfg_burst_mode),
    .req_pin        (req_pin),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .xfer_done      (xfer_done),
    .ack_pin        (ack_pin),
    .cfg_err        (cfg_err)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(input logic a, input logic e, input logic s, input logic b);
    cfg_ack_high = a; cfg_edge_mode = e; cfg_sense_high = s; cfg_burst_mode = b;
    cfg_we = 1'b1;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; standby = 1'b0; mod_stby = 1'b0; cfg_we = 1'b0;
    cfg_ack_high = 1'b0; cfg_edge_mode = 1'b0; cfg_sense_high = 1'b0; cfg_burst_mode = 1'b0;
    req_pin = 1'b1; req_ready = 1'b0; xfer_done = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick();
    chk("R1", "reset valid", req_valid, 1'b0);
    chk("R1", "reset ack idle", ack_pin, 1'b1);
    chk("R1", "reset err", cfg_err, 1'b0);

    // Sweep all control combinations.
    for (int c = 0; c < 16; c++) begin
      logic a, e, s, b, err;
      a = c[3]; e = c[2]; s = c[1]; b = c[0];
      err = !e && b;
      req_pin = ~s;
      tick(4);
      write_cfg(a, e, s, b);
      tick(3);
      chk("R2", "idle ack", ack_pin, ~a);
      chk("R8", "err flag", cfg_err, err);
      chk("R5", "inactive level no request", req_valid, 1'b0);
      if (err) begin
        req_ready = 1'b1;
        req_pin = s;
        for (int k = 0; k < 6; k++) begin
          tick();
          if (k == 2) req_pin = ~s;
          if (k == 4) req_pin = s;
          chk("R8", "blocked valid", req_valid, 1'b0);
          chk("R8", "blocked ack", ack_pin, ~a);
        end
        req_ready = 1'b0;
        req_pin = ~s;
      end else if (!e) begin
        req_pin = s;
        tick();
        chk("R3", "level valid after 1 edge", req_valid, 1'b0);
        tick();
        chk("R3", "level valid after 2 edges", req_valid, 1'b1);
        tick(3);
        chk("R3", "level valid held", req_valid, 1'b1);
        req_ready = 1'b1;
        tick();
        chk("R6", "cs ack active", ack_pin, a);
        req_ready = 1'b0;
        tick();
        chk("R6", "cs ack single cycle", ack_pin, ~a);
        req_pin = ~s;
        tick();
        chk("R3", "level release 1 edge", req_valid, 1'b1);
        tick();
        chk("R3", "level release 2 edges", req_valid, 1'b0);
      end else begin
        req_pin = s;
        tick(2);
        chk("R4", "edge valid after 2 edges", req_valid, 1'b0);
        tick();
        chk("R4", "edge valid after 3 edges", req_valid, 1'b1);
        req_pin = ~s;
        tick(4);
        chk("R4", "edge held under back-pressure", req_valid, 1'b1);
        chk("R6", "no ack before accept", ack_pin, ~a);
        req_ready = 1'b1;
        tick();
        req_ready = 1'b0;
        chk("R4", "valid dropped on accept", req_valid, 1'b0);
        chk(b ? "R7" : "R6", "ack after accept", ack_pin, a);
        if (b) begin
          tick(4);
          chk("R7", "burst ack held", ack_pin, a);
          xfer_done = 1'b1;
          tick();
          xfer_done = 1'b0;
          chk("R7", "burst ack released", ack_pin, ~a);
        end else begin
          tick();
          chk("R6", "cs ack single cycle", ack_pin, ~a);
        end
        tick(3);
        chk("R5", "opposite edge ignored", req_valid, 1'b0);
      end
    end

    // Module standby during a burst.
    req_pin = 1'b0;
    tick(4);
    write_cfg(1'b1, 1'b1, 1'b1, 1'b1);
    tick(3);
    req_pin = 1'b1;
    tick(3);
    req_ready = 1'b1;
    tick();
    req_ready = 1'b0;
    chk("R7", "burst ack before standby", ack_pin, 1'b1);
    mod_stby = 1'b1;
    #1;
    chk("R9", "ack forced inactive", ack_pin, 1'b0);
    for (int k = 0; k < 8; k++) begin
      req_pin = k[0];
      tick();
      chk("R9", "valid during module standby", req_valid, 1'b0);
    end
    req_pin = 1'b1;
    tick(4);
    mod_stby = 1'b0;
    tick(3);
    chk("R9", "no edge kept from module standby", req_valid, 1'b0);
    chk("R9", "ack polarity retained", ack_pin, 1'b0);
    chk("R9", "no err after module standby", cfg_err, 1'b0);
    req_pin = 1'b0;
    tick(4);
    req_pin = 1'b1;
    tick(3);
    chk("R9", "edge mode retained", req_valid, 1'b1);
    req_ready = 1'b1;
    tick();
    req_ready = 1'b0;
    tick(3);
    chk("R9", "burst mode retained", ack_pin, 1'b1);

    // Configuration write ends the burst and drops a pending edge.
    write_cfg(1'b1, 1'b1, 1'b1, 1'b1);
    chk("R10", "write ends ack", ack_pin, 1'b0);
    req_pin = 1'b0;
    tick(4);
    req_pin = 1'b1;
    tick(3);
    chk("R4", "second edge pending", req_valid, 1'b1);
    write_cfg(1'b1, 1'b1, 1'b1, 1'b1);
    chk("R10", "write drops pending", req_valid, 1'b0);
    tick(3);
    chk("R10", "pending stays dropped", req_valid, 1'b0);

    // Standby clears the control bits.
    standby = 1'b1;
    tick();
    standby = 1'b0;
    chk("R1", "standby ack idle high", ack_pin, 1'b1);
    chk("R1", "standby err", cfg_err, 1'b0);
    req_pin = 1'b0;
    tick(2);
    chk("R1", "standby level-low default", req_valid, 1'b1);

    finish_run();
  end
endmodule